// File: doc/BRIEF.md
# Video and Pseudo-SRAM Bus Glue Decoder

This block is the glue logic between a 16-bit CPU with a 24-bit address bus and two kinds of target: a video controller attached through an ISA-style strobe interface, and two banks of pseudo-SRAM, each built from a low-byte (even) device and a high-byte (odd) device. From the CPU address, the address strobe and the read and byte-write strobes, it produces the video memory and video I/O strobes, the bus-high-enable, one chip enable per byte lane of each memory bank, the refresh and odd-side write strobes, and a bus-swap control.

The same video memory is reached through two address windows. The wide window allows word and byte cycles and always presents a CPU read to the video controller as a 16-bit cycle. The narrow window is for graphics code and performs only byte cycles. Both windows produce the same offset into video memory. The video controller's ready signal is too slow to stall the first bus cycle. For this reason the block adds its own short wait at the start of every video cycle and ORs it with the controller's wait before sending the result to the CPU.

Top module: `vidram_bus_glue`

## Requirements
- R1: Wide window: an address in C00000h..C1FFFFh with the strobe low drives `vmem_rd_n` low on a read and `vmem_wr_n` low on either byte write. `vmem_ofs` carries address bits 16:0.
- R2: Narrow window: an address in C80000h..C9FFFFh gives the same strobes and the same `vmem_ofs` (address bits 16:0) as the wide window.
- R3: Bus-high-enable: `bhe_n` is low for every read in the wide window. It is also low for a wide-window or video I/O cycle that has the high-byte write or A0=1. In the narrow window it is low only when A0=1.
- R4: The video memory and video I/O strobes (`vio_rd_n`, `vio_wr_n`, the latter selected by `vio_sel_n` low) go low only while `as_n` is low. Outside the windows they stay high.
- R5: A video cycle (either window, or `vio_sel_n` low, with `as_n` low) holds the internal wait for WAIT_CLKS rising edges (default 1). The wait is then released even if the strobe is still low. It is armed again only after `as_n` has been high across a rising edge.
- R6: `cpu_wait_n` is low whenever the internal wait is active or `vga_wait_n` is low.
- R7: A memory bank is selected when `mem_dec_n` is low, `as_n` is low, and address bits 23:20 equal 8h (bank index 0) or 9h (bank index 1). Any other tag selects no bank.
- R8: Lanes of a selected bank: the even enable is active on a read with A0=0 or on a low-byte write. The odd enable is active on any read or on a high-byte write.
- R9: `odd_wr_n` is low for a bank access with the high-byte write, or with the low-byte write at A0=1 while `ipl_n` is low.
- R10: `mem_rfsh_n` follows `rfsh_n` outside reset.
- R11: `swap_n` is low for a bank access while `ipl_n` is low. It stays high for video cycles.
- R12: While `rst_n` is low, `rst_out` is high and every strobe, enable and wait output stays inactive. When `rst_n` is high, `rst_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 24 | CPU address |
| as_n | input | 1 | Address strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| hwr_n | input | 1 | High-byte write, active low |
| lwr_n | input | 1 | Low-byte write, active low |
| rfsh_n | input | 1 | CPU refresh request, active low |
| ipl_n | input | 1 | Boot-loader phase flag, active low |
| mem_dec_n | input | 1 | Memory-controller decode for the bank region, active low |
| vio_sel_n | input | 1 | Video I/O decode, active low |
| vga_wait_n | input | 1 | Ready-based wait from the video controller, active low |
| vmem_rd_n | output | 1 | Video memory read strobe |
| vmem_wr_n | output | 1 | Video memory write strobe |
| vio_rd_n | output | 1 | Video I/O read strobe |
| vio_wr_n | output | 1 | Video I/O write strobe |
| bhe_n | output | 1 | Bus-high-enable to the video controller |
| vmem_ofs | output | 17 | Offset into video memory |
| ps_even_ce_n | output | 2 | Even-lane chip enable, one bit per bank |
| ps_odd_ce_n | output | 2 | Odd-lane chip enable, one bit per bank |
| odd_wr_n | output | 1 | Odd-side write strobe |
| mem_rfsh_n | output | 1 | Refresh strobe to the memory banks |
| swap_n | output | 1 | Bus-swap control |
| cpu_wait_n | output | 1 | Combined wait to the CPU |
| rst_out | output | 1 | Active-high reset output |

## Verification
A table of bus cycles drives each window with even and odd addresses, with reads, low-byte, high-byte and word writes, and with the boot flag set and clear. These patterns separate the wide window's forced 16-bit reads from the narrow window's byte-only lane rule, and separate an even-lane enable from an odd-lane enable. Near-miss addresses (C20000h, CA0000h, A00000h) and a missing memory-controller decode show that the window comparisons are exact. Directed sequences then hold the strobe for several clocks and release it again, which shows that the internal wait lasts one clock and re-arms. They also overlap the controller's wait with the internal one, and drive the strobes while reset is held or the address strobe is high.

// File: rtl/glue_pkg.sv
package glue_pkg;

    // One CPU bus cycle, all fields active high
    typedef struct packed {
        logic as;
        logic rd;
        logic hwr;
        logic lwr;
        logic a0;
        logic ipl;
    } bus_req_t;

    typedef struct packed {
        logic even;
        logic odd;
    } lanes_t;

endpackage

// File: rtl/glue_win_decode.sv
module glue_win_decode #(
    parameter int              ADDR_W   = 24,
    parameter int              SPAN_LOG = 17,
    parameter logic [23:0]     BASE     = 24'hC0_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TAG_W = ADDR_W - SPAN_LOG;
    localparam logic [TAG_W-1:0] TAG = BASE[ADDR_W-1:SPAN_LOG];

    always_comb begin
        hit = (addr[ADDR_W-1:SPAN_LOG] == TAG);
    end
endmodule

// File: rtl/glue_lane_ctl.sv
module glue_lane_ctl
    import glue_pkg::*;
(
    input  logic     sel,
    input  bus_req_t req,
    output lanes_t   lanes
);
    always_comb begin
        lanes.even = sel & ((req.rd & ~req.a0) | req.lwr);
        lanes.odd  = sel & (req.rd | req.hwr);
    end
endmodule

// File: rtl/glue_wait_gen.sv
module glue_wait_gen #(
    parameter int WAIT_CLKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vid_act,
    output logic int_wait
);
    localparam int CNT_W = $clog2(WAIT_CLKS + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(WAIT_CLKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!vid_act)
            st_d.cnt = '0;
        else if (st_q.cnt < LIM)
            st_d.cnt = st_q.cnt + CNT_W'(1);
        int_wait = vid_act && (st_q.cnt < LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: counter never passes its limit
    p_wait_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIM);
    // R5: after an idle edge, a new video cycle starts with the wait raised
    p_wait_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_act |=> (!vid_act || int_wait));
    // R5: the wait clears while the cycle is still running
    p_wait_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_act && st_q.cnt == LIM) |-> !int_wait);
endmodule

// File: rtl/vidram_bus_glue.sv
module vidram_bus_glue
    import glue_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          VWIN_LOG  = 17,
    parameter logic [23:0] VWIN_WIDE = 24'hC0_0000,
    parameter logic [23:0] VWIN_BYTE = 24'hC8_0000,
    parameter int          BANK_LOG  = 20,
    parameter logic [23:0] BANK_BASE = 24'h80_0000,
    parameter int          NUM_BANKS = 2,
    parameter int          WAIT_CLKS = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [23:0]          addr,
    input  logic                 as_n,
    input  logic                 rd_n,
    input  logic                 hwr_n,
    input  logic                 lwr_n,
    input  logic                 rfsh_n,
    input  logic                 ipl_n,
    input  logic                 mem_dec_n,
    input  logic                 vio_sel_n,
    input  logic                 vga_wait_n,
    output logic                 vmem_rd_n,
    output logic                 vmem_wr_n,
    output logic                 vio_rd_n,
    output logic                 vio_wr_n,
    output logic                 bhe_n,
    output logic [16:0]          vmem_ofs,
    output logic [NUM_BANKS-1:0] ps_even_ce_n,
    output logic [NUM_BANKS-1:0] ps_odd_ce_n,
    output logic                 odd_wr_n,
    output logic                 mem_rfsh_n,
    output logic                 swap_n,
    output logic                 cpu_wait_n,
    output logic                 rst_out
);
    localparam int OFS_W = VWIN_LOG;

    bus_req_t req;
    logic     win_wide, win_byte, vid_mem, vid_io, vid_act, int_wait;
    logic     acc, wr_any;
    logic [NUM_BANKS-1:0] bank_hit, bank_sel;
    lanes_t   lanes [NUM_BANKS];

    // Bus request, gated by reset so all decodes fall silent (R12)
    always_comb begin
        req.as  = rst_n & ~as_n;
        req.rd  = ~rd_n;
        req.hwr = ~hwr_n;
        req.lwr = ~lwr_n;
        req.a0  = addr[0];
        req.ipl = ~ipl_n;
        wr_any  = req.hwr | req.lwr;
        acc     = req.rd | wr_any;
    end

    glue_win_decode #(.ADDR_W(ADDR_W), .SPAN_LOG(VWIN_LOG), .BASE(VWIN_WIDE))
        u_win_wide (.addr(addr), .hit(win_wide));
    glue_win_decode #(.ADDR_W(ADDR_W), .SPAN_LOG(VWIN_LOG), .BASE(VWIN_BYTE))
        u_win_byte (.addr(addr), .hit(win_byte));

    always_comb begin
        vid_mem = req.as & (win_wide | win_byte);
        vid_io  = req.as & ~vio_sel_n;
        vid_act = vid_mem | vid_io;
    end

    // Video strobes (R1, R2, R4)
    always_comb begin
        vmem_rd_n = ~(vid_mem & req.rd);
        vmem_wr_n = ~(vid_mem & wr_any);
        vio_rd_n  = ~(vid_io & req.rd);
        vio_wr_n  = ~(vid_io & wr_any);
        vmem_ofs  = vid_mem ? addr[OFS_W-1:0] : '0;
    end

    // Bus-high-enable (R3)
    always_comb begin
        logic hi_wide, hi_byte, hi_io;
        hi_wide = req.as & win_wide & (req.rd | req.hwr | (req.a0 & req.lwr));
        hi_byte = req.as & win_byte & req.a0 & acc;
        hi_io   = vid_io & acc & (req.hwr | req.a0);
        bhe_n   = ~(hi_wide | hi_byte | hi_io);
    end

    // Memory banks (R7, R8)
    genvar gi;
    generate
        for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
            localparam logic [23:0] BB = BANK_BASE + (24'(gi) << BANK_LOG);
            glue_win_decode #(.ADDR_W(ADDR_W), .SPAN_LOG(BANK_LOG), .BASE(BB))
                u_bank_dec (.addr(addr), .hit(bank_hit[gi]));
            assign bank_sel[gi] = bank_hit[gi] & req.as & ~mem_dec_n;
            glue_lane_ctl u_lane (.sel(bank_sel[gi]), .req(req), .lanes(lanes[gi]));
            assign ps_even_ce_n[gi] = ~lanes[gi].even;
            assign ps_odd_ce_n[gi]  = ~lanes[gi].odd;
        end
    endgenerate

    // Odd write, swap, refresh, reset out (R9, R10, R11, R12)
    always_comb begin
        logic any_bank;
        any_bank   = |bank_sel;
        odd_wr_n   = ~(any_bank & (req.hwr | (req.ipl & req.lwr & req.a0)));
        swap_n     = ~(any_bank & req.ipl);
        mem_rfsh_n = ~(rst_n & ~rfsh_n);
        rst_out    = ~rst_n;
    end

    glue_wait_gen #(.WAIT_CLKS(WAIT_CLKS)) u_wait (
        .clk(clk), .rst_n(rst_n), .vid_act(vid_act), .int_wait(int_wait));

    // Combined wait (R6)
    always_comb begin
        cpu_wait_n = ~(rst_n & (int_wait | ~vga_wait_n));
    end

    // R4: video strobes require the address strobe
    p_strobe_as_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!vmem_rd_n || !vmem_wr_n || !vio_rd_n || !vio_wr_n) |-> !as_n);
    // R3: narrow window never drives the high lane on an even address
    p_bhe_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_byte && !win_wide && vio_sel_n && !addr[0]) |-> bhe_n);
    // R7: at most one bank is enabled at a time
    p_bank_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~(ps_even_ce_n & ps_odd_ce_n)));
    // R6: controller wait always reaches the CPU
    p_wait_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !vga_wait_n |-> !cpu_wait_n);
    // R11: no swap during a video cycle
    p_no_swap_video_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vid_mem |-> swap_n);
    // R12: everything quiet in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r12: assert (rst_out && vmem_rd_n && vmem_wr_n && vio_rd_n
                && vio_wr_n && bhe_n && (&ps_even_ce_n) && (&ps_odd_ce_n)
                && odd_wr_n && swap_n && cpu_wait_n && mem_rfsh_n);
        end
    end
endmodule

// File: tb/vidram_bus_glue_bench.sv
module vidram_bus_glue_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic as_n = 1, rd_n = 1, hwr_n = 1, lwr_n = 1, rfsh_n = 1, ipl_n = 1;
    logic mem_dec_n = 1, vio_sel_n = 1, vga_wait_n = 1;
    logic vmem_rd_n, vmem_wr_n, vio_rd_n, vio_wr_n, bhe_n, odd_wr_n;
    logic mem_rfsh_n, swap_n, cpu_wait_n, rst_out;
    logic [16:0] vmem_ofs;
    logic [1:0] ps_even_ce_n, ps_odd_ce_n;
    int nchk = 0, nfail = 0;

    always #2.5 clk = ~clk;

    vidram_bus_glue u_vidram_bus_glue (.*);

    // {addr, rd,hwr,lwr,ipl,memdec,viosel, exp: vrd vwr iord iowr bhe b0e b0o b1e b1o owr swp}
    localparam int NV = 23;
    localparam logic [40:0] VEC [NV] = '{
        {24'hC00000, 6'b100000, 11'b10001000000},  // R1 R3 word read
        {24'hC00001, 6'b100000, 11'b10001000000},  // R3 byte read forced wide
        {24'hC01234, 6'b001000, 11'b01000000000},  // R1 low write
        {24'hC01235, 6'b010000, 11'b01001000000},  // R3 high write
        {24'hC1FFFE, 6'b011000, 11'b01001000000},  // R1 word write top
        {24'hC80000, 6'b100000, 11'b10000000000},  // R2 R3 even byte
        {24'hC9FFFF, 6'b100000, 11'b10001000000},  // R2 R3 odd byte
        {24'hC80010, 6'b001000, 11'b01000000000},  // R2 write
        {24'hC20000, 6'b100000, 11'b00000000000},  // R4 near miss
        {24'hCA0000, 6'b100000, 11'b00000000000},  // R4 near miss
        {24'hF00100, 6'b100001, 11'b00100000000},  // R4 io read
        {24'hF00101, 6'b010001, 11'b00011000000},  // R3 R4 io high write
        {24'h800000, 6'b100010, 11'b00000110000},  // R8 word read bank0
        {24'h800001, 6'b100010, 11'b00000010000},  // R8 odd read
        {24'h900000, 6'b001010, 11'b00000001000},  // R7 R8 bank1 low
        {24'h900001, 6'b010010, 11'b00000000110},  // R9 bank1 high
        {24'h8FFFFE, 6'b011010, 11'b00000110010},  // R8 R9 word write
        {24'h800000, 6'b100000, 11'b00000000000},  // R7 no decode
        {24'hA00000, 6'b100010, 11'b00000000000},  // R7 wrong tag
        {24'h800000, 6'b100110, 11'b00000110001},  // R11 ipl read
        {24'h800001, 6'b001110, 11'b00000100011},  // R9 R11 ipl odd low write
        {24'h800000, 6'b001110, 11'b00000100001},  // R9 ipl even low write
        {24'hC00000, 6'b100100, 11'b10001000000}   // R11 no swap on video
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] outs();
        return ~{vmem_rd_n, vmem_wr_n, vio_rd_n, vio_wr_n, bhe_n, ps_even_ce_n[0],
                 ps_odd_ce_n[0], ps_even_ce_n[1], ps_odd_ce_n[1], odd_wr_n, swap_n};
    endfunction

    task automatic idle();
        @(negedge clk);
        as_n = 1; rd_n = 1; hwr_n = 1; lwr_n = 1; ipl_n = 1; mem_dec_n = 1; vio_sel_n = 1;
        @(posedge clk);
    endtask

    task automatic drive(input logic [23:0] a, input logic [5:0] c);
        addr = a; as_n = 0;
        rd_n = ~c[5]; hwr_n = ~c[4]; lwr_n = ~c[3]; ipl_n = ~c[2];
        mem_dec_n = ~c[1]; vio_sel_n = ~c[0];
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R12 reset state with a live video read and refresh driven
        drive(24'hC00000, 6'b100000);
        rfsh_n = 0;
        #1;
        chk("R12 strobes in reset", 32'(outs()), 32'h0);
        chk("R12 rst_out high", 32'(rst_out), 32'h1);
        chk("R12 wait quiet", 32'(cpu_wait_n), 32'h1);
        chk("R12 refresh quiet", 32'(mem_rfsh_n), 32'h1);
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1; rfsh_n = 1; as_n = 1; rd_n = 1;
        #1;
        chk("R12 rst_out low", 32'(rst_out), 32'h0);
        @(posedge clk);

        // Table of cycles
        for (int i = 0; i < NV; i++) begin
            logic [10:0] e;
            logic vid;
            e = VEC[i][10:0];
            vid = |e[10:7];
            @(negedge clk);
            drive(VEC[i][40:17], VEC[i][16:11]);
            #1;
            chk($sformatf("R1-table vec%0d outputs", i), 32'(outs()), 32'(e));
            chk($sformatf("R5 vec%0d first wait", i), 32'(cpu_wait_n), 32'(!vid));
            @(posedge clk); #1;
            chk($sformatf("R5 vec%0d wait released", i), 32'(cpu_wait_n), 32'h1);
            chk($sformatf("R8 vec%0d held outputs", i), 32'(outs()), 32'(e));
            idle();
        end

        // R1 R2 offset from both windows
        @(negedge clk); drive(24'hC01234, 6'b100000); #1;
        chk("R1 wide offset", 32'(vmem_ofs), 32'h01234);
        idle();
        @(negedge clk); drive(24'hC81234, 6'b100000); #1;
        chk("R2 narrow offset", 32'(vmem_ofs), 32'h01234);
        idle();

        // R4 no strobes without address strobe
        @(negedge clk); drive(24'hC00000, 6'b100001); as_n = 1; #1;
        chk("R4 strobes need as", 32'(outs()), 32'h0);
        chk("R4 no wait without as", 32'(cpu_wait_n), 32'h1);
        idle();

        // R5 long hold then re-arm
        @(negedge clk); drive(24'hC00000, 6'b100000); #1;
        chk("R5 hold first", 32'(cpu_wait_n), 32'h0);
        repeat (3) @(posedge clk); #1;
        chk("R5 hold later", 32'(cpu_wait_n), 32'h1);
        idle();
        @(negedge clk); drive(24'hC80000, 6'b001000); #1;
        chk("R5 rearmed", 32'(cpu_wait_n), 32'h0);
        idle();

        // R6 controller wait alone and overlapping
        @(negedge clk); vga_wait_n = 0; #1;
        chk("R6 controller wait idle", 32'(cpu_wait_n), 32'h0);
        drive(24'hC00000, 6'b100000);
        @(posedge clk); #1;
        chk("R6 controller wait held", 32'(cpu_wait_n), 32'h0);
        vga_wait_n = 1; #1;
        chk("R6 controller wait released", 32'(cpu_wait_n), 32'h1);
        idle();

        // R10 refresh follows
        @(negedge clk); rfsh_n = 0; #1;
        chk("R10 refresh low", 32'(mem_rfsh_n), 32'h0);
        rfsh_n = 1; #1;
        chk("R10 refresh high", 32'(mem_rfsh_n), 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule